// File: doc/BRIEF.md
# Transfer Unit Framing Scheduler

This block sits in the framing path of a packetised display link. It decides how many valid video bytes go into each fixed-size transfer unit on a lane, and how many stuffing bytes fill the rest of the unit. Software sets up the unit size, the whole number of data bytes per unit, the fractional remainder scaled by one thousand, and the pixel colour format. The scheduler then carries the fractional part forward from unit to unit, so that over a line the average number of data bytes per unit matches the programmed ratio.

At the start of each video line a strobe restarts the schedule. The strobe clears the fractional carry and loads a wait countdown. The length of the countdown depends on the format. While the countdown runs no unit is emitted, which gives an upstream FIFO time to prefill. Once the countdown reaches zero, the block emits one unit descriptor per clock until the next line strobe.

The configuration is captured by a single write strobe that updates all fields at once. Values outside the legal range are corrected when they are written.

Top module: `tu_sched`

## Requirements
- R1: The stored unit size resets to 64. A written size below 32 is stored as 32, and a written size above 64 is stored as 64.
- R2: Bit 0 of the stored unit size is always zero, so a written odd size such as 41 is stored as 40.
- R3: A written fractional value above 999 is stored as 999.
- R4: When the minimum data bytes per unit is 4 or less, the line-start wait is 64 cycles, whatever the format.
- R5: After a line strobe, wait_cnt_o shows the loaded wait W on the next cycle and then counts down by one per cycle. unit_valid_o stays low for exactly W cycles and is then high every cycle until the next strobe.
- R6: When the minimum is above 4, the wait is based on D = size − minimum, and D is 0 when the minimum is at least the size. The wait is D for format code 0 (RGB / 4:4:4) and for the spare code 3. It is floor(D/2) for code 1 (4:2:2) and floor(D/3) for code 2 (luma only).
- R7: For each emitted unit, the fractional value is added to an accumulator that is always below 1000. When the sum is 1000 or more, 1000 is subtracted and that unit carries minimum+1 data bytes. Otherwise the unit carries the minimum.
- R8: A line strobe clears the accumulator, even when it arrives while units are being emitted. The first unit after the strobe then adds the fraction to zero.
- R9: The data byte count is clamped to the unit size, and the stuffing count equals the unit size minus the data byte count.
- R10: After reset and before the first line strobe, unit_valid_o is low and wait_cnt_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Captures all configuration fields |
| cfg_tu_size_i | input | 7 | Transfer unit size in bytes |
| cfg_min_bytes_i | input | 8 | Whole data bytes per unit |
| cfg_frac_i | input | 10 | Fractional data bytes per unit, times 1000 |
| cfg_fmt_i | input | 2 | Colour format: 0 RGB/4:4:4, 1 4:2:2, 2 luma only, 3 treated as 0 |
| sol_i | input | 1 | Start-of-line strobe |
| unit_valid_o | output | 1 | A unit descriptor is presented this cycle |
| data_bytes_o | output | 7 | Data bytes in the current unit |
| stuff_bytes_o | output | 7 | Stuffing bytes in the current unit |
| wait_cnt_o | output | 8 | Remaining line-start wait cycles |

## Verification
The bench targets the following corner cases:

- **Odd and out-of-range sizes.** A design that fails to clear bit 0 or to clamp the range reports a wrong stuffing count and a wrong wait.
- **Minimum at or above the unit size.** Here a missing clamp wraps the stuffing count and makes the wait enormous.
- **Minimum exactly 4.** This catches an off-by-one in the small-ratio test.
- **Largest fraction, with an over-range write.** This exposes a missing or wrong carry or a missing fraction clamp, because the long run of minimum+1 units shifts.
- **Line strobe arriving mid-stream with a partly filled accumulator.** A design that does not clear the accumulator emits a carry on the first unit of the new line.

// File: rtl/tu_sched_pkg.sv
package tu_sched_pkg;
  localparam int TU_W       = 7;
  localparam int MIN_W      = 8;
  localparam int FRAC_W     = 10;
  localparam int WAIT_W     = 8;
  localparam int FRAC_ONE   = 1000;
  localparam int TU_LO      = 32;
  localparam int TU_HI      = 64;
  localparam int TU_RST     = 64;
  localparam int SMALL_MIN  = 4;
  localparam int SMALL_WAIT = 64;

  typedef enum logic [1:0] {
    FMT_RGB  = 2'd0,
    FMT_422  = 2'd1,
    FMT_LUMA = 2'd2,
    FMT_SPR  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [TU_W-1:0]   tu;
    logic [MIN_W-1:0]  min_bytes;
    logic [FRAC_W-1:0] frac;
    fmt_e              fmt;
  } cfg_t;
endpackage

// File: rtl/tu_cfg_regs.sv
module tu_cfg_regs
  import tu_sched_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TU_W-1:0]   tu_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [1:0]        fmt_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      if (tu_i < TU_W'(TU_LO))      cfg_d.tu = TU_W'(TU_LO);
      else if (tu_i > TU_W'(TU_HI)) cfg_d.tu = TU_W'(TU_HI);
      else                          cfg_d.tu = tu_i;
      cfg_d.tu[0]     = 1'b0;
      cfg_d.min_bytes = min_i;
      cfg_d.frac      = (frac_i > FRAC_W'(FRAC_ONE - 1)) ? FRAC_W'(FRAC_ONE - 1) : frac_i;
      cfg_d.fmt       = fmt_e'(fmt_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.tu        <= TU_W'(TU_RST);
      cfg_q.min_bytes <= '0;
      cfg_q.frac      <= '0;
      cfg_q.fmt       <= FMT_RGB;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  p_tu_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.tu >= TU_W'(TU_LO)) && (cfg_q.tu <= TU_W'(TU_HI)));
  p_tu_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_q.tu[0] == 1'b0));
  p_frac_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_q.frac < FRAC_W'(FRAC_ONE)));
endmodule

// File: rtl/tu_wait_calc.sv
module tu_wait_calc
  import tu_sched_pkg::*;
(
  input  cfg_t              cfg_i,
  output logic [WAIT_W-1:0] wait_o
);
  logic [MIN_W-1:0] tu_ext, diff;

  always_comb begin
    tu_ext = MIN_W'(cfg_i.tu);
    diff   = (cfg_i.min_bytes >= tu_ext) ? '0 : tu_ext - cfg_i.min_bytes;
    if (cfg_i.min_bytes <= MIN_W'(SMALL_MIN)) begin
      wait_o = WAIT_W'(SMALL_WAIT);
    end else begin
      unique case (cfg_i.fmt)
        FMT_422:  wait_o = WAIT_W'(diff >> 1);
        FMT_LUMA: wait_o = WAIT_W'(diff / MIN_W'(3));
        default:  wait_o = WAIT_W'(diff);
      endcase
    end
  end
endmodule

// File: rtl/tu_frac_acc.sv
module tu_frac_acc
  import tu_sched_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [TU_W-1:0]   tu_i,
  output logic [TU_W-1:0]   data_o,
  output logic [TU_W-1:0]   stuff_o
);
  localparam int SUM_W = FRAC_W + 1;
  localparam int RAW_W = MIN_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;
  logic              carry;
  logic [RAW_W-1:0]  raw;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, frac_i};
    carry   = (sum >= SUM_W'(FRAC_ONE));
    raw     = {1'b0, min_i} + RAW_W'(carry);
    data_o  = (raw > RAW_W'(tu_i)) ? tu_i : TU_W'(raw);
    stuff_o = tu_i - data_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= carry ? FRAC_W'(sum - SUM_W'(FRAC_ONE)) : FRAC_W'(sum);
  end

  p_acc_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < FRAC_W'(FRAC_ONE));
  p_acc_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0));
  p_acc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/tu_sched.sv
module tu_sched
  import tu_sched_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TU_W-1:0]   cfg_tu_size_i,
  input  logic [MIN_W-1:0]  cfg_min_bytes_i,
  input  logic [FRAC_W-1:0] cfg_frac_i,
  input  logic [1:0]        cfg_fmt_i,
  input  logic              sol_i,
  output logic              unit_valid_o,
  output logic [TU_W-1:0]   data_bytes_o,
  output logic [TU_W-1:0]   stuff_bytes_o,
  output logic [WAIT_W-1:0] wait_cnt_o
);
  cfg_t              cfg;
  logic [WAIT_W-1:0] wait_val, wait_q;
  logic              active_q;

  tu_cfg_regs u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .tu_i   (cfg_tu_size_i),
    .min_i  (cfg_min_bytes_i),
    .frac_i (cfg_frac_i),
    .fmt_i  (cfg_fmt_i),
    .cfg_o  (cfg)
  );

  tu_wait_calc u_wait (
    .cfg_i  (cfg),
    .wait_o (wait_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q   <= '0;
      active_q <= 1'b0;
    end else if (sol_i) begin
      wait_q   <= wait_val;
      active_q <= 1'b1;
    end else if (wait_q != '0) begin
      wait_q   <= wait_q - 1'b1;
    end
  end

  assign unit_valid_o = active_q && (wait_q == '0);
  assign wait_cnt_o   = wait_q;

  tu_frac_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sol_i),
    .step_i  (unit_valid_o && !sol_i),
    .frac_i  (cfg.frac),
    .min_i   (cfg.min_bytes),
    .tu_i    (cfg.tu),
    .data_o  (data_bytes_o),
    .stuff_o (stuff_bytes_o)
  );

  p_wait_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sol_i && wait_q != '0) |=> (wait_q == WAIT_W'($past(wait_q) - 1'b1)));
  p_no_unit_in_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q != '0) |-> !unit_valid_o);
  p_split_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_valid_o |-> ((data_bytes_o + stuff_bytes_o) == cfg.tu));
  p_data_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_bytes_o <= cfg.tu);
  p_sol_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_i |=> (wait_q == $past(wait_val)));
endmodule

// File: tb/tu_sched_test.sv
module tu_sched_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [6:0] cfg_tu_size_i = '0;
  logic [7:0] cfg_min_bytes_i = '0;
  logic [9:0] cfg_frac_i = '0;
  logic [1:0] cfg_fmt_i = '0;
  logic       sol_i = 1'b0;
  logic       unit_valid_o;
  logic [6:0] data_bytes_o, stuff_bytes_o;
  logic [7:0] wait_cnt_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tu_sched uut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_tu_size_i, .cfg_min_bytes_i,
    .cfg_frac_i, .cfg_fmt_i, .sol_i, .unit_valid_o, .data_bytes_o,
    .stuff_bytes_o, .wait_cnt_o
  );

  // {tu_in[34:28], min[27:20], frac_in[19:10], fmt[9:8], exp_wait[7:0]}
  localparam int NV = 10;
  localparam logic [34:0] VEC [NV] = '{
    {7'd64,  8'd20, 10'd250,  2'd0, 8'd44},
    {7'd41,  8'd10, 10'd0,    2'd0, 8'd30},
    {7'd64,  8'd10, 10'd0,    2'd1, 8'd27},
    {7'd64,  8'd10, 10'd0,    2'd2, 8'd18},
    {7'd64,  8'd5,  10'd0,    2'd2, 8'd19},
    {7'd64,  8'd4,  10'd700,  2'd1, 8'd64},
    {7'd20,  8'd10, 10'd500,  2'd0, 8'd22},
    {7'd100, 8'd30, 10'd1023, 2'd3, 8'd34},
    {7'd64,  8'd70, 10'd300,  2'd0, 8'd0},
    {7'd50,  8'd25, 10'd333,  2'd1, 8'd12}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_tu(input int t);
    int r;
    r = (t < 32) ? 32 : ((t > 64) ? 64 : t);
    return r - (r % 2);
  endfunction

  function automatic int eff_frac(input int f);
    return (f > 999) ? 999 : f;
  endfunction

  task automatic write_cfg(input int tu, input int mn, input int fr, input int fmt);
    cfg_tu_size_i   = 7'(tu);
    cfg_min_bytes_i = 8'(mn);
    cfg_frac_i      = 10'(fr);
    cfg_fmt_i       = 2'(fmt);
    cfg_we_i        = 1'b1;
    @(negedge clk_i);
    cfg_we_i        = 1'b0;
  endtask

  task automatic run_line(input int tu, input int mn, input int fr, input int w,
                          input int nunits, input string tag);
    int acc, cnt;
    sol_i = 1'b1;
    @(negedge clk_i);
    sol_i = 1'b0;
    check(wait_cnt_o == 8'(w), {tag, " R5 wait load"}, wait_cnt_o, w);
    cnt = 0;
    while (!unit_valid_o && cnt < 300) begin
      cnt++;
      @(negedge clk_i);
    end
    check(cnt == w, {tag, " R5/R6 wait cycles"}, cnt, w);
    acc = 0;
    for (int k = 0; k < nunits; k++) begin
      int s, d;
      s = acc + fr;
      d = mn + ((s >= 1000) ? 1 : 0);
      acc = (s >= 1000) ? s - 1000 : s;
      if (d > tu) d = tu;
      check(unit_valid_o == 1'b1, {tag, " R5 unit valid"}, unit_valid_o, 1);
      check(data_bytes_o == 7'(d), {tag, " R7 data bytes"}, data_bytes_o, d);
      check(stuff_bytes_o == 7'(tu - d), {tag, " R9 stuff bytes"}, stuff_bytes_o, tu - d);
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: idle before first strobe
    for (int i = 0; i < 3; i++) begin
      check(unit_valid_o == 1'b0, "R10 valid idle", unit_valid_o, 0);
      check(wait_cnt_o == 8'd0, "R10 wait idle", wait_cnt_o, 0);
      @(negedge clk_i);
    end
    // R1 reset size 64, min 0 -> R4 wait 64
    run_line(64, 0, 0, 64, 3, "R1 reset cfg");

    for (int i = 0; i < NV; i++) begin
      int t, m, f, fm, w;
      t  = int'(VEC[i][34:28]);
      m  = int'(VEC[i][27:20]);
      f  = int'(VEC[i][19:10]);
      fm = int'(VEC[i][9:8]);
      w  = int'(VEC[i][7:0]);
      write_cfg(t, m, f, fm);
      run_line(eff_tu(t), m, eff_frac(f), w, 12, $sformatf("vec%0d R1 R2 R3 R4 R6", i));
    end

    // R8: strobe mid-stream with accumulator at 800
    write_cfg(64, 20, 400, 0);
    run_line(64, 20, 400, 44, 2, "R8 first");
    run_line(64, 20, 400, 44, 4, "R8 restart");

    // R9: minimum exactly at unit size
    write_cfg(40, 40, 999, 0);
    run_line(40, 40, 999, 0, 4, "R9 full unit");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule